// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

A parameterised register (eight bits by default) that can keep its value, shift toward its high end, shift toward its low end, or capture a word from a shared parallel bus. The parallel lines are one tri-state bus. They deliver the word to be captured, and they carry the register contents back out when the block is allowed to drive them. In this model the bus is split into a data-in vector, a data-out vector and one drive-enable flag. The pad ring or the bus fabric joins them.

Two active-low enables gate the bus drivers. The drivers also switch off by themselves in load mode, so an external source can own the lines while the block captures them. A serial tap at each end of the register is always driven. An active-low clear empties the register at once and does not wait for the clock.

Bit 0 is the low end ("A") and bit WIDTH-1 is the high end ("H").

Top module: `univ_shift_bus`

## Requirements
- R1: `mode_sel` is decoded as 2'b00 hold, 2'b01 shift right, 2'b10 shift left and 2'b11 load. In hold, a rising clock edge leaves the register unchanged.
- R2: While `clr_n` is low, the register reads all zeros. This takes effect immediately, even in the middle of a clock cycle, and holds across rising edges whatever the mode.
- R3: In mode 2'b01, each rising edge moves `ser_r` into bit 0 and moves each bit i-1 into bit i.
- R4: In mode 2'b10, each rising edge moves `ser_l` into bit WIDTH-1 and moves each bit i+1 into bit i.
- R5: In mode 2'b11, each rising edge copies `bus_din` into the register.
- R6: `bus_drive` is high exactly when `oe_a_n` and `oe_b_n` are both low and the mode is not 2'b11. `bus_dout` always carries the register contents.
- R7: Holding either enable high stops the bus drive but does not change shifting, loading or clearing.
- R8: `tap_lo` always equals bit 0 and `tap_hi` always equals bit WIDTH-1, whatever the enables and the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | Operating mode select |
| ser_r | input | 1 | Serial input entering bit 0 on a right shift |
| ser_l | input | 1 | Serial input entering the top bit on a left shift |
| oe_a_n | input | 1 | Bus drive enable, active low |
| oe_b_n | input | 1 | Bus drive enable, active low |
| bus_din | input | WIDTH | Receive side of the shared bus |
| bus_dout | output | WIDTH | Transmit side of the shared bus (register contents) |
| bus_drive | output | 1 | Drive-enable for the bus buffers |
| tap_lo | output | 1 | Bit 0 serial tap |
| tap_hi | output | 1 | Top-bit serial tap |

## Verification
The clear can fall inside the same cycle as a mode that would otherwise update the register. The test raises a load or a shift, lowers `clr_n` half a clock period later, and checks the outputs before the next edge to confirm that the zeros appeared without a clock. It keeps clear low across an edge where mode 11 presents a full word and checks that the register stays empty. It also issues a short clear pulse that ends before the next edge. Each mode result is compared with a bench reference model, and the bus drive flag is judged against the enables and the mode in the same cycle.

// File: rtl/usr_pkg.sv
package usr_pkg;

   typedef enum logic [1:0] {
      USR_HOLD = 2'b00,
      USR_SHR  = 2'b01,
      USR_SHL  = 2'b10,
      USR_LOAD = 2'b11
   } usr_mode_e;

   typedef struct packed {
      logic hold;
      logic shr;
      logic shl;
      logic load;
   } usr_sel_t;

endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
   import usr_pkg::*;
(
   input  logic [1:0] mode_sel,
   output usr_sel_t   sel
);
   usr_mode_e mode;

   always_comb begin
      mode = usr_mode_e'(mode_sel);
      sel  = '0;
      unique case (mode)
         USR_HOLD: sel.hold = 1'b1;
         USR_SHR:  sel.shr  = 1'b1;
         USR_SHL:  sel.shl  = 1'b1;
         USR_LOAD: sel.load = 1'b1;
         default:  sel.hold = 1'b1;
      endcase
   end
endmodule

// File: rtl/usr_bit_slice.sv
module usr_bit_slice
   import usr_pkg::*;
(
   input  usr_sel_t sel,
   input  logic     cur,
   input  logic     from_lo,
   input  logic     from_hi,
   input  logic     ext,
   output logic     nxt
);
   always_comb begin
      nxt = cur;
      if (sel.shr)       nxt = from_lo;
      else if (sel.shl)  nxt = from_hi;
      else if (sel.load) nxt = ext;
   end
endmodule

// File: rtl/usr_reg_core.sv
module usr_reg_core
   import usr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  usr_sel_t         sel,
   input  logic             ser_r,
   input  logic             ser_l,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q
);
   localparam int EXT_W = WIDTH + 2;

   logic [EXT_W-1:0] ext_q;
   logic [WIDTH-1:0] q_nxt;

   // neighbour vector: serial inputs at both ends
   assign ext_q = {ser_l, q, ser_r};

   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      usr_bit_slice u_slice (
         .sel     (sel),
         .cur     (q[i]),
         .from_lo (ext_q[i]),
         .from_hi (ext_q[i+2]),
         .ext     (din[i]),
         .nxt     (q_nxt[i])
      );
   end

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) q <= '0;
      else        q <= q_nxt;
   end

   logic armed;
   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   a_r1_hold_keeps: assert property (@(posedge clk) disable iff (!clr_n || !armed)
      sel.hold |=> q == $past(q));
   a_r2_clear_zero: assert property (@(posedge clk)
      !clr_n |-> q == '0);
   a_r3_shift_right: assert property (@(posedge clk) disable iff (!clr_n || !armed)
      sel.shr |=> q == {$past(q[WIDTH-2:0]), $past(ser_r)});
   a_r4_shift_left: assert property (@(posedge clk) disable iff (!clr_n || !armed)
      sel.shl |=> q == {$past(ser_l), $past(q[WIDTH-1:1])});
   a_r5_load_capture: assert property (@(posedge clk) disable iff (!clr_n || !armed)
      sel.load |=> q == $past(din));
endmodule

// File: rtl/usr_bus_ctrl.sv
module usr_bus_ctrl
   import usr_pkg::*;
(
   input  logic     oe_a_n,
   input  logic     oe_b_n,
   input  usr_sel_t sel,
   output logic     drive
);
   always_comb drive = !oe_a_n && !oe_b_n && !sel.load;
endmodule

// File: rtl/univ_shift_bus.sv
module univ_shift_bus
   import usr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [1:0]       mode_sel,
   input  logic             ser_r,
   input  logic             ser_l,
   input  logic             oe_a_n,
   input  logic             oe_b_n,
   input  logic [WIDTH-1:0] bus_din,
   output logic [WIDTH-1:0] bus_dout,
   output logic             bus_drive,
   output logic             tap_lo,
   output logic             tap_hi
);
   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("univ_shift_bus: WIDTH must be at least 2");
   end

   usr_sel_t         sel;
   logic [WIDTH-1:0] q;

   usr_mode_dec u_dec (
      .mode_sel (mode_sel),
      .sel      (sel)
   );

   usr_reg_core #(.WIDTH(WIDTH)) u_core (
      .clk   (clk),
      .clr_n (clr_n),
      .sel   (sel),
      .ser_r (ser_r),
      .ser_l (ser_l),
      .din   (bus_din),
      .q     (q)
   );

   usr_bus_ctrl u_bus (
      .oe_a_n (oe_a_n),
      .oe_b_n (oe_b_n),
      .sel    (sel),
      .drive  (bus_drive)
   );

   assign bus_dout = q;
   assign tap_lo   = q[0];
   assign tap_hi   = q[TOP];

   a_r6_quiet_on_load: assert property (@(posedge clk) disable iff (!clr_n)
      mode_sel == 2'b11 |-> !bus_drive);
   a_r7_enable_blocks: assert property (@(posedge clk) disable iff (!clr_n)
      (oe_a_n || oe_b_n) |-> !bus_drive);
   a_r8_taps_follow: assert property (@(posedge clk) disable iff (!clr_n)
      tap_lo == bus_dout[0] && tap_hi == bus_dout[TOP]);
endmodule

// File: tb/univ_shift_bus_tb_top.sv
`timescale 1ns/1ps
module univ_shift_bus_tb_top;
   localparam int W = 8;
   localparam int NV = 16;

   logic         clk = 1'b0;
   logic         clr_n;
   logic [1:0]   mode_sel;
   logic         ser_r, ser_l, oe_a_n, oe_b_n;
   logic [W-1:0] bus_din;
   logic [W-1:0] bus_dout;
   logic         bus_drive, tap_lo, tap_hi;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   univ_shift_bus #(.WIDTH(W)) dut_i (
      .clk(clk), .clr_n(clr_n), .mode_sel(mode_sel), .ser_r(ser_r),
      .ser_l(ser_l), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_din(bus_din),
      .bus_dout(bus_dout), .bus_drive(bus_drive), .tap_lo(tap_lo), .tap_hi(tap_hi)
   );

   // {mode[1:0], ser_r, ser_l, oe_a_n, oe_b_n, din[7:0], expected drive}
   localparam logic [14:0] VEC [NV] = '{
      {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0},
      {2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1},
      {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b1},
      {2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
      {2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0},
      {2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b1},
      {2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 1'b0},
      {2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b0},
      {2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0},
      {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1},
      {2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0},
      {2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1},
      {2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0},
      {2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 1'b0},
      {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1},
      {2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3, 1'b1}
   };

   function automatic logic [W-1:0] ref_next(input logic [1:0] m, input logic [W-1:0] q,
                                             input logic r, input logic l,
                                             input logic [W-1:0] d);
      case (m)
         2'b01:   return {q[W-2:0], r};
         2'b10:   return {l, q[W-1:1]};
         2'b11:   return d;
         default: return q;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] model;
      string tag;
      clr_n = 1'b0; mode_sel = 2'b00; ser_r = 1'b0; ser_l = 1'b0;
      oe_a_n = 1'b0; oe_b_n = 1'b0; bus_din = '0;
      repeat (2) @(posedge clk);
      #1;
      // R2: reset state
      chk(bus_dout == '0, "R2 reset contents", bus_dout, '0);
      chk({tap_hi, tap_lo} == 2'b00, "R8 reset taps", {6'd0, tap_hi, tap_lo}, '0);
      @(negedge clk) clr_n = 1'b1;
      model = '0;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {mode_sel, ser_r, ser_l, oe_a_n, oe_b_n, bus_din} = VEC[i][14:1];
         model = ref_next(VEC[i][14:13], model, VEC[i][12], VEC[i][11], VEC[i][8:1]);
         @(posedge clk);
         #1;
         case (mode_sel)
            2'b00:   tag = "R1 hold";
            2'b01:   tag = "R3 shift right";
            2'b10:   tag = "R4 shift left";
            default: tag = "R5 load";
         endcase
         if ((oe_a_n || oe_b_n) && mode_sel != 2'b00) tag = {tag, " R7 enables high"};
         chk(bus_dout == model, tag, bus_dout, model);
         chk(bus_drive == VEC[i][0], "R6 drive flag", {7'd0, bus_drive}, {7'd0, VEC[i][0]});
         chk(tap_lo == model[0] && tap_hi == model[W-1], "R8 taps",
             {6'd0, tap_hi, tap_lo}, {6'd0, model[W-1], model[0]});
      end

      // R2: clear in mid-cycle after a load
      @(negedge clk);
      mode_sel = 2'b11; bus_din = 8'hFF; oe_a_n = 1'b0; oe_b_n = 1'b0;
      @(posedge clk);
      #1;
      chk(bus_dout == 8'hFF, "R5 load before clear", bus_dout, 8'hFF);
      #0.5 clr_n = 1'b0;
      #0.5;
      chk(bus_dout == '0, "R2 mid-cycle clear", bus_dout, '0);
      chk({tap_hi, tap_lo} == 2'b00, "R8 taps on clear", {6'd0, tap_hi, tap_lo}, '0);
      // R2: clear held across an edge with load presenting data
      bus_din = 8'hAA;
      @(posedge clk);
      #1;
      chk(bus_dout == '0, "R2 clear overrides load", bus_dout, '0);
      @(negedge clk);
      clr_n = 1'b1; mode_sel = 2'b00;
      @(posedge clk);
      #1;
      chk(bus_dout == '0, "R1 hold after clear", bus_dout, '0);
      chk(bus_drive == 1'b1, "R6 drive after clear", {7'd0, bus_drive}, 8'h01);

      // R2 and R7: short clear pulse with enables high, during a shift
      @(negedge clk);
      mode_sel = 2'b11; bus_din = 8'h5A; oe_a_n = 1'b1;
      @(posedge clk);
      #1;
      chk(bus_dout == 8'h5A, "R7 load with enable high", bus_dout, 8'h5A);
      mode_sel = 2'b01; ser_r = 1'b1;
      clr_n = 1'b0;
      #1 clr_n = 1'b1;
      #0.2;
      chk(bus_dout == '0, "R2 clear pulse", bus_dout, '0);
      @(posedge clk);
      #1;
      chk(bus_dout == 8'h01, "R3 shift after clear pulse", bus_dout, 8'h01);
      chk(bus_drive == 1'b0, "R7 drive off with enable high", {7'd0, bus_drive}, '0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule